// File: doc/BRIEF.md
# Redundant-Binary Carry-Recoding Precoder

This block takes an operand in redundant binary form and partly compresses it without any carry-propagate addition. The operand is one of two kinds. It can be a carry-save pair of rows, where each digit is the sum of two bits and the top column has negative weight. It can also be a borrow-save pair, where each digit is a positive bit minus a negative bit. The block passes the operand through three rows of carry-recoding cells. Each cell turns one input column into a carry, which goes one column up, and a residual, which stays in place. Cells never talk to their neighbours, so the logic depth is three cell levels whatever the operand width.

The first row depends on the format. Carry-save input goes through a row that emits positive carries. Borrow-save input goes through a row that emits negative carries. After that, both paths pass through one more negative-carry row and then one positive-carry row. The result is a borrow-save pair three columns wider than the input, with the same value.

The useful property is a narrow fraction range. If the output is cut at any column, the dropped low part lies in a window of width 1+1/8 ulp. Every aligned pair of output digits therefore has a radix-4 value in {-2..2}, and the negative bit of its upper column gives that pair's sign. This lets the output feed a plain radix-4 multiplier digit selector as if it were a compressed number.

Top module: `rbp_precoder`

## Requirements
- R1: With `fmt_cs`=1, the rows are carry-save. Input digit i (i < NDIG-1) is `row_a[i]+row_b[i]` with weight 2^i, and digit NDIG-1 is `-(row_a+row_b)` with weight 2^(NDIG-1). The output value Σ(`out_pos[i]`-`out_neg[i]`)·2^i over NDIG+3 columns equals the input value.
- R2: With `fmt_cs`=0, the rows are borrow-save. Input digit i is `row_a[i]-row_b[i]` with weight 2^i. The output value equals the input value, so an all-zero input gives an all-zero output.
- R3: For every cut position j from 1 to NDIG+2, the value L of the output digits below column j satisfies 8·L < 4·2^j. It also satisfies 8·L > -5·2^j in borrow-save mode, and 8·L ≥ -5·2^j in carry-save mode.
- R4: Every aligned digit pair (columns 2w+1 and 2w, for 2w+1 < NDIG+3) has value 2·d(2w+1)+d(2w) in {-2,-1,0,1,2}.
- R5: In each aligned pair, if `out_neg[2w+1]`=1 the pair value is ≤ 0, and if it is 0 the pair value is ≥ 0.
- R6: `out_pos[0]` and `out_neg[NDIG+2]` are always 0.
- R7: In borrow-save mode, a column with both input bits 1 gives the same output as that column with both bits 0.
- R8: In carry-save mode, swapping `row_a` and `row_b` leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_cs | input | 1 | 1: the rows are carry-save; 0: the rows are borrow-save |
| row_a | input | NDIG | Carry-save first row, or borrow-save positive bits |
| row_b | input | NDIG | Carry-save second row, or borrow-save negative bits |
| out_pos | output | NDIG+3 | Output positive bits, column 0 at bit 0 |
| out_neg | output | NDIG+3 | Output negative bits, column 0 at bit 0 |

## Verification
Value preservation and range compression hold together on the same output, so every vector is judged for both at once. The exact value must match the input, and the low-part bounds must hold at every cut position and for every digit pair. Carry-save vectors with the sign column set, and borrow-save vectors full of (1,1) columns, test the sign-column cell and the redundant zero encoding in the same vectors that test the range bound. A three-digit instance is run over every input combination in both formats, so the edge columns are covered completely.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    typedef enum logic [1:0] {
        CELL_P = 2'd0,
        CELL_N = 2'd1,
        CELL_Q = 2'd2
    } cell_kind_e;

    typedef struct packed {
        logic carry;
        logic resid;
    } cell_out_t;

    // positive carry out of a borrow-save column, negative residual left behind
    function automatic cell_out_t p_cell(input logic pb, input logic nb);
        cell_out_t r;
        r.carry = pb & ~nb;
        r.resid = pb ^ nb;
        return r;
    endfunction

    // negative carry out of a borrow-save column, positive residual left behind
    function automatic cell_out_t n_cell(input logic pb, input logic nb);
        cell_out_t r;
        r.carry = nb & ~pb;
        r.resid = pb ^ nb;
        return r;
    endfunction

    // carry-save column of positive weight: digit 0..2 -> 2*carry - resid
    function automatic cell_out_t q_cell(input logic xb, input logic yb);
        cell_out_t r;
        r.carry = xb | yb;
        r.resid = xb ^ yb;
        return r;
    endfunction

    // carry-save column of negative weight: -(x+y) -> -2*carry - resid
    function automatic cell_out_t q_sign_cell(input logic xb, input logic yb);
        cell_out_t r;
        r.carry = xb & yb;
        r.resid = xb ^ yb;
        return r;
    endfunction

endpackage

// File: rtl/rbp_row.sv
module rbp_row
    import rbp_pkg::*;
#(
    parameter int         W    = 16,
    parameter cell_kind_e KIND = CELL_P
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    output logic [W:0]   pos_o,
    output logic [W:0]   neg_o
);

    logic [W-1:0] cy;
    logic [W-1:0] rs;

    for (genvar i = 0; i < W; i++) begin : g_col
        cell_out_t c;
        if (KIND == CELL_P) begin : g_p
            assign c = p_cell(hi_i[i], lo_i[i]);
        end else if (KIND == CELL_N) begin : g_n
            assign c = n_cell(hi_i[i], lo_i[i]);
        end else if (i == W-1) begin : g_qs
            assign c = q_sign_cell(hi_i[i], lo_i[i]);
        end else begin : g_q
            assign c = q_cell(hi_i[i], lo_i[i]);
        end
        assign cy[i] = c.carry;
        assign rs[i] = c.resid;
    end

    if (KIND == CELL_P) begin : g_place_p
        assign pos_o = {cy, 1'b0};
        assign neg_o = {1'b0, rs};
    end else if (KIND == CELL_N) begin : g_place_n
        assign pos_o = {1'b0, rs};
        assign neg_o = {cy, 1'b0};
    end else begin : g_place_q
        assign pos_o = {1'b0, cy[W-2:0], 1'b0};
        assign neg_o = {cy[W-1], rs};
    end

endmodule

// File: rtl/rbp_entry.sv
module rbp_entry
    import rbp_pkg::*;
#(
    parameter int K = 16
) (
    input  logic         fmt_cs,
    input  logic [K-1:0] row_a,
    input  logic [K-1:0] row_b,
    output logic [K:0]   pos_o,
    output logic [K:0]   neg_o
);

    logic [K:0] q_pos, q_neg, n_pos, n_neg;

    rbp_row #(.W(K), .KIND(CELL_Q)) u_qrow (
        .hi_i (row_a),
        .lo_i (row_b),
        .pos_o(q_pos),
        .neg_o(q_neg)
    );

    rbp_row #(.W(K), .KIND(CELL_N)) u_nrow (
        .hi_i (row_a),
        .lo_i (row_b),
        .pos_o(n_pos),
        .neg_o(n_neg)
    );

    assign pos_o = fmt_cs ? q_pos : n_pos;
    assign neg_o = fmt_cs ? q_neg : n_neg;

endmodule

// File: rtl/rbp_precoder.sv
module rbp_precoder
    import rbp_pkg::*;
#(
    parameter int NDIG = 16
) (
    input  logic              fmt_cs,
    input  logic [NDIG-1:0]   row_a,
    input  logic [NDIG-1:0]   row_b,
    output logic [NDIG+2:0]   out_pos,
    output logic [NDIG+2:0]   out_neg
);

    localparam int W1 = NDIG + 1;
    localparam int W2 = NDIG + 2;

    logic [W1-1:0] s1_pos, s1_neg;
    logic [W2-1:0] s2_pos, s2_neg;

    rbp_entry #(.K(NDIG)) u_entry (
        .fmt_cs(fmt_cs),
        .row_a (row_a),
        .row_b (row_b),
        .pos_o (s1_pos),
        .neg_o (s1_neg)
    );

    rbp_row #(.W(W1), .KIND(CELL_N)) u_mid (
        .hi_i (s1_pos),
        .lo_i (s1_neg),
        .pos_o(s2_pos),
        .neg_o(s2_neg)
    );

    rbp_row #(.W(W2), .KIND(CELL_P)) u_last (
        .hi_i (s2_pos),
        .lo_i (s2_neg),
        .pos_o(out_pos),
        .neg_o(out_neg)
    );

endmodule

// File: rtl/rbp_checker.sv
module rbp_checker #(
    parameter int NDIG = 16
) (
    input logic            fmt_cs,
    input logic [NDIG-1:0] row_a,
    input logic [NDIG-1:0] row_b,
    input logic [NDIG+2:0] out_pos,
    input logic [NDIG+2:0] out_neg
);

    localparam int OCOLS = NDIG + 3;
    localparam int SW    = NDIG + 8;

    typedef logic signed [SW-1:0] sv_t;

    sv_t  in_val, out_val, low, scaled, lim_lo, lim_hi;
    logic frac_ok, win_ok, sign_ok;

    always_comb begin
        int dg;
        int pv;
        in_val = '0;
        for (int i = 0; i < NDIG; i++) begin
            if (fmt_cs) dg = int'(row_a[i]) + int'(row_b[i]);
            else        dg = int'(row_a[i]) - int'(row_b[i]);
            if (fmt_cs && i == NDIG-1) dg = -dg;
            in_val = in_val + (sv_t'(dg) <<< i);
        end

        low     = '0;
        frac_ok = 1'b1;
        scaled  = '0;
        lim_lo  = '0;
        lim_hi  = '0;
        for (int j = 0; j < OCOLS; j++) begin
            if (j > 0) begin
                scaled = low <<< 3;
                lim_hi = sv_t'(4) <<< j;
                lim_lo = -(sv_t'(5) <<< j);
                if (!(scaled < lim_hi)) frac_ok = 1'b0;
                if (fmt_cs ? (scaled < lim_lo) : (scaled <= lim_lo)) frac_ok = 1'b0;
            end
            dg  = int'(out_pos[j]) - int'(out_neg[j]);
            low = low + (sv_t'(dg) <<< j);
        end
        out_val = low;

        win_ok  = 1'b1;
        sign_ok = 1'b1;
        for (int w = 0; w < OCOLS/2; w++) begin
            pv = 2 * (int'(out_pos[2*w+1]) - int'(out_neg[2*w+1]))
               + (int'(out_pos[2*w]) - int'(out_neg[2*w]));
            if (pv > 2 || pv < -2) win_ok = 1'b0;
            if (out_neg[2*w+1] && pv > 0)  sign_ok = 1'b0;
            if (!out_neg[2*w+1] && pv < 0) sign_ok = 1'b0;
        end
    end

    always_comb begin
        p_value_cs_r1: assert (!fmt_cs || in_val == out_val)
            else $error("carry-save value changed");
        p_value_bs_r2: assert (fmt_cs || in_val == out_val)
            else $error("borrow-save value changed");
        p_frac_range_r3: assert (frac_ok)
            else $error("low-part range exceeded");
        p_pair_bound_r4: assert (win_ok)
            else $error("digit pair outside -2..2");
        p_pair_sign_r5: assert (sign_ok)
            else $error("pair sign disagrees with upper negative bit");
        p_edge_zero_r6: assert (!out_pos[0] && !out_neg[OCOLS-1])
            else $error("edge bit set");
    end

endmodule

bind rbp_precoder rbp_checker #(.NDIG(NDIG)) u_chk (
    .fmt_cs (fmt_cs),
    .row_a  (row_a),
    .row_b  (row_b),
    .out_pos(out_pos),
    .out_neg(out_neg)
);

// File: tb/sim_rbp_precoder.sv
module sim_rbp_precoder;

    localparam int KA = 16;
    localparam int KB = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst;
    logic          cs0;
    logic [KA-1:0] a0, b0;
    logic [KA+2:0] po0, no0;
    logic          cs1;
    logic [KB-1:0] a1, b1;
    logic [KB+2:0] po1, no1;

    int n_chk = 0;
    int n_bad = 0;

    rbp_precoder #(.NDIG(KA)) u0 (
        .fmt_cs(cs0), .row_a(a0), .row_b(b0), .out_pos(po0), .out_neg(no0));

    rbp_precoder #(.NDIG(KB)) u1 (
        .fmt_cs(cs1), .row_a(a1), .row_b(b1), .out_pos(po1), .out_neg(no1));

    task automatic tally(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint in_value(input bit cs, input logic [31:0] a,
                                        input logic [31:0] b, input int k);
        longint v = 0;
        for (int i = 0; i < k; i++) begin
            longint d = cs ? (longint'(a[i]) + longint'(b[i]))
                           : (longint'(a[i]) - longint'(b[i]));
            if (cs && i == k-1) d = -d;
            v += d * (longint'(1) << i);
        end
        return v;
    endfunction

    task automatic judge(input int k, input bit cs, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] po, input logic [31:0] no);
        longint want = in_value(cs, a, b, k);
        longint low = 0;
        bit     fr_ok = 1'b1;
        longint fr_act = 0, fr_exp = 0;
        bit     w_ok = 1'b1, s_ok = 1'b1;
        longint w_act = 0, s_act = 0;
        for (int j = 0; j < k + 3; j++) begin
            if (j > 0) begin
                longint hi = longint'(4) << j;
                longint lo = -(longint'(5) << j);
                bit bad = (8 * low >= hi) || (cs ? (8 * low < lo) : (8 * low <= lo));
                if (bad && fr_ok) begin
                    fr_ok  = 1'b0;
                    fr_act = 8 * low;
                    fr_exp = (8 * low >= hi) ? hi : lo;
                end
            end
            low += (longint'(po[j]) - longint'(no[j])) * (longint'(1) << j);
        end
        tally(low == want, cs ? "R1 value carry-save" : "R2 value borrow-save", low, want);
        tally(fr_ok, "R3 low-part range (8*L vs bound)", fr_act, fr_exp);
        for (int w = 0; w < (k + 3) / 2; w++) begin
            longint pv = 2 * (longint'(po[2*w+1]) - longint'(no[2*w+1]))
                       + (longint'(po[2*w]) - longint'(no[2*w]));
            if ((pv > 2 || pv < -2) && w_ok) begin w_ok = 1'b0; w_act = pv; end
            if (((no[2*w+1] && pv > 0) || (!no[2*w+1] && pv < 0)) && s_ok) begin
                s_ok = 1'b0; s_act = pv;
            end
        end
        tally(w_ok, "R4 pair value in -2..2", w_act, 2);
        tally(s_ok, "R5 pair sign", s_act, 0);
        tally(!po[0] && !no[k+2], "R6 edge bits zero", longint'({po[0], no[k+2]}), 0);
    endtask

    task automatic run0(input bit cs, input logic [KA-1:0] a, input logic [KA-1:0] b);
        @(posedge clk);
        #1;
        cs0 = cs; a0 = a; b0 = b;
        @(negedge clk);
        judge(KA, cs, 32'(a), 32'(b), 32'(po0), 32'(no0));
    endtask

    task automatic run1(input bit cs, input logic [KB-1:0] a, input logic [KB-1:0] b);
        @(posedge clk);
        #1;
        cs1 = cs; a1 = a; b1 = b;
        @(negedge clk);
        judge(KB, cs, 32'(a), 32'(b), 32'(po1), 32'(no1));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        longint ref0, alt0;
        logic [KA-1:0] ra, rb, m;
        rst = 1'b1;
        cs0 = 1'b0; a0 = '0; b0 = '0;
        cs1 = 1'b0; a1 = '0; b1 = '0;
        void'($urandom(32'h5eed_0c0d));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: zero in gives zero out
        tally(po0 == '0 && no0 == '0, "R2 zero input", longint'({po0, no0}), 0);

        // directed corners (R1, R2, R3, R4, R5, R6)
        run0(1'b1, '1, '1);
        run0(1'b1, '1, '0);
        run0(1'b1, {1'b1, {(KA-1){1'b0}}}, '0);
        run0(1'b1, {1'b0, {(KA-1){1'b1}}}, {1'b0, {(KA-1){1'b1}}});
        run0(1'b0, '1, '0);
        run0(1'b0, '0, '1);
        run0(1'b0, {(KA/2){2'b10}}, {(KA/2){2'b01}});
        run0(1'b0, '1, '1);

        for (int t = 0; t < 400; t++) begin
            run0(1'($urandom), KA'($urandom), KA'($urandom));
        end

        // exhaustive small instance, both formats
        for (int cs = 0; cs < 2; cs++)
            for (int a = 0; a < (1 << KB); a++)
                for (int b = 0; b < (1 << KB); b++)
                    run1(1'(cs), KB'(a), KB'(b));

        // R7: a (1,1) borrow-save column behaves as (0,0)
        for (int t = 0; t < 40; t++) begin
            ra = KA'($urandom);
            rb = KA'($urandom);
            m  = KA'(1) << ($urandom % KA);
            run0(1'b0, ra | m, rb | m);
            ref0 = longint'({po0, no0});
            run0(1'b0, ra & ~m, rb & ~m);
            alt0 = longint'({po0, no0});
            tally(ref0 == alt0, "R7 (1,1) column same as (0,0)", alt0, ref0);
        end

        // R8: carry-save rows are interchangeable
        for (int t = 0; t < 40; t++) begin
            ra = KA'($urandom);
            rb = KA'($urandom);
            run0(1'b1, ra, rb);
            ref0 = longint'({po0, no0});
            run0(1'b1, rb, ra);
            alt0 = longint'({po0, no0});
            tally(ref0 == alt0, "R8 swapped carry-save rows", alt0, ref0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule